// File: doc/BRIEF.md
# SPI Master Transfer-Start and Interrupt Controller

This block is the control core of an SPI master. It contains the single-word transmit and receive buffers, a serial shifter, and a small DMA sequencer. A two-bit mode input selects what starts each word. In the core-receive mode, reading the receive buffer starts a word. In the core-transmit mode, writing the transmit buffer starts a word. In the DMA mode, a rising DMA enable starts a sequence of words, and each word is paced by a request/acknowledge handshake. The fourth encoding is reserved and starts nothing. No start bit exists: every transfer starts from a buffer access.

The interrupt output is a level. In the core-receive mode it is high while the receive buffer holds a word. In the core-transmit mode it is high while the transmit buffer is empty. In both core modes the access that changes that state, or clearing the port enable, drops it in the same cycle. In the DMA mode it is a one-cycle pulse when the word count runs out.

The host side uses single-cycle strobes (`tx_wr`, `rx_rd`) and needs no back-pressure. A buffer access that arrives during a word is held as pending. The DMA side uses a level request that the requester holds until it sees one acknowledge cycle. One acknowledge moves one word.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: After reset, `sclk` and `mosi` are low, `irq` is low and `dma_req` is low.
- R2: In mode 2'b00, a cycle with `rx_rd` starts one word. With no such read, and even after a `tx_wr` (which only loads the transmit buffer), no `sclk` edge appears. The word shifted out is the last value written to the transmit buffer.
- R3: In mode 2'b00, `irq` is high in each cycle in which the receive buffer holds a word. It goes low combinationally in a cycle that has `rx_rd`, or that has `port_en` low.
- R4: In mode 2'b01, a cycle with `tx_wr` starts a word that shifts out `tx_wdata`. At the end of the word, the received byte appears on `rx_data`.
- R5: In mode 2'b01, `irq` is high while the transmit buffer is empty. It is low in the cycle of `tx_wr`. If the write arrives during a word, `irq` stays low until that written word starts shifting.
- R6: Each word is 8 bits, MSB first, in SPI mode 0. `sclk` idles low and has a period of CLK_DIV system cycles. `mosi` changes on the falling edge and `miso` is sampled on the rising edge.
- R7: An access that arrives during a word is held as pending. The next word starts one cycle after the current one ends, so the last rising edge of one word and the first rising edge of the next are CLK_DIV+1 cycles apart.
- R8: In mode 2'b10 with `rcv_dir`=0, a rising `dma_en` loads the count from `dma_len`. `dma_req` is high while the count is non-zero and the transmit buffer is empty. Each acknowledge writes `dma_wdata` and starts a word. Exactly `dma_len` words are sent.
- R9: In mode 2'b10 with `rcv_dir`=1, a rising `dma_en` starts the first word. `dma_req` is high while the receive buffer is full. Each acknowledge reads `rx_data`, and every acknowledge except the last starts the next word.
- R10: In mode 2'b10, `irq` pulses for exactly one cycle: the cycle after the acknowledge that takes the count from 1 to 0.
- R11: In mode 2'b11, no word starts and `irq` stays low, whatever the strobes do.
- R12: With `port_en` low, any word in progress is aborted (`sclk` low on the next cycle), both buffers are marked empty, strobes are ignored and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low aborts and empties |
| mode | input | 2 | 00 core-receive, 01 core-transmit, 10 DMA, 11 reserved |
| rcv_dir | input | 1 | DMA direction: 1 receive-paced, 0 transmit-paced |
| tx_wr | input | 1 | Host write strobe for the transmit buffer |
| tx_wdata | input | 8 | Host write data |
| rx_rd | input | 1 | Host read strobe for the receive buffer |
| rx_data | output | 8 | Receive buffer contents |
| irq | output | 1 | Interrupt level or pulse, depending on mode |
| dma_en | input | 1 | DMA enable; a rising edge starts a sequence |
| dma_len | input | 8 | Word count loaded on that rising edge |
| dma_req | output | 1 | DMA word request |
| dma_ack | input | 1 | DMA acknowledge; one cycle moves one word |
| dma_wdata | input | 8 | DMA write data for the transmit buffer |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench targets the first transfer in the receive-driven mode. A design that starts it without the initial dummy read, or on a buffer write, would show clock edges before the read. It checks that the interrupt drops in the very cycle of the emptying access or of the disable; a registered version would stay high one cycle too long. It measures the one-cycle gap between a word and its pending successor, which a design that drops or delays the pending start would get wrong. It also checks that the DMA interrupt is a single pulse that follows the last acknowledge and that no extra word is sent. Finally it aborts a word mid-flight and checks that the buffers are empty on re-enable, which catches a design that keeps stale state.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    XM_CORE_RX = 2'b00,
    XM_CORE_TX = 2'b01,
    XM_DMA     = 2'b10,
    XM_RSVD    = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/spi_shift_engine.sv
// Serial shifter: SPI mode 0, MSB first, sclk = clk / CLK_DIV.
module spi_shift_engine #(
  parameter int WIDTH   = 8,
  parameter int CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [WIDTH-1:0] tx_word,
  input  logic             miso,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic             done,
  output logic [WIDTH-1:0] rx_word
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [DW-1:0]    div_q;
  logic [BW-1:0]    bit_q;
  logic [WIDTH-1:0] tx_sh, rx_sh;
  logic             busy_q, sclk_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
        sclk_q <= 1'b0;
        div_q  <= '0;
        bit_q  <= '0;
      end else if (start && !busy_q) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        div_q  <= '0;
        bit_q  <= '0;
        tx_sh  <= tx_word;
      end else if (busy_q) begin
        if (div_q == DW'(HALF - 1)) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_sh  <= {rx_sh[WIDTH-2:0], miso};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == BW'(WIDTH - 1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_sh <= {tx_sh[WIDTH-2:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_sh[WIDTH-1];
  assign done    = done_q;
  assign rx_word = rx_sh;

  // R7: the controller never requests a start into a busy shifter
  assert_start_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |-> !busy_q);
  // R6: a word end follows a cycle that was shifting
  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));
endmodule

// File: rtl/spi_dma_seq.sv
// Word-count sequencer for the DMA-paced mode.
module spi_dma_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             dma_en,
  input  logic [CNT_W-1:0] dma_len,
  input  logic             rcv_dir,
  input  logic             tx_full,
  input  logic             rx_full,
  input  logic             dma_ack,
  output logic             dma_req,
  output logic             dma_wr,
  output logic             dma_rd,
  output logic             kick,
  output logic             last
);
  logic             en_prev_q, active_q, last_q, go, acc;
  logic [CNT_W-1:0] cnt_q;

  assign go      = enable && dma_en && !en_prev_q;
  assign dma_req = enable && active_q && (cnt_q != '0) && (rcv_dir ? rx_full : !tx_full);
  assign acc     = dma_req && dma_ack;
  assign dma_wr  = acc && !rcv_dir;
  assign dma_rd  = acc && rcv_dir;
  assign kick    = (go && rcv_dir && (dma_len != '0)) ||
                   dma_wr || (dma_rd && (cnt_q != CNT_W'(1)));
  assign last    = last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev_q <= 1'b0;
      active_q  <= 1'b0;
      last_q    <= 1'b0;
      cnt_q     <= '0;
    end else begin
      en_prev_q <= dma_en;
      last_q    <= acc && (cnt_q == CNT_W'(1));
      if (!enable || !dma_en) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (go) begin
        active_q <= (dma_len != '0);
        cnt_q    <= dma_len;
      end else if (acc) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) active_q <= 1'b0;
      end
    end
  end

  // R10: the end pulse comes only once the count is exhausted
  assert_last_means_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> (cnt_q == '0));
  // R8: an acknowledged word always reduces the count by one
  assert_ack_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && enable && dma_en) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl #(
  parameter int WIDTH   = 8,
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic [1:0]       mode,
  input  logic             rcv_dir,
  input  logic             tx_wr,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             rx_rd,
  output logic [WIDTH-1:0] rx_data,
  output logic             irq,
  input  logic             dma_en,
  input  logic [CNT_W-1:0] dma_len,
  output logic             dma_req,
  input  logic             dma_ack,
  input  logic [WIDTH-1:0] dma_wdata,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  import spi_xfer_pkg::*;

  xfer_mode_e       mode_e;
  logic             host_wr, host_rd, dma_wr, dma_rd, dma_kick, dma_last;
  logic             trig, start_req, eng_start, eng_busy, eng_done;
  logic             pend_q, tx_full_q, rx_full_q;
  logic [WIDTH-1:0] tx_buf_q, rx_buf_q, eng_rx, eng_tx;

  assign mode_e  = xfer_mode_e'(mode);
  assign host_wr = port_en && tx_wr;
  assign host_rd = port_en && rx_rd;

  spi_dma_seq #(.CNT_W(CNT_W)) u_dma (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (port_en && (mode_e == XM_DMA)),
    .dma_en  (dma_en),
    .dma_len (dma_len),
    .rcv_dir (rcv_dir),
    .tx_full (tx_full_q),
    .rx_full (rx_full_q),
    .dma_ack (dma_ack),
    .dma_req (dma_req),
    .dma_wr  (dma_wr),
    .dma_rd  (dma_rd),
    .kick    (dma_kick),
    .last    (dma_last)
  );

  always_comb begin
    unique case (mode_e)
      XM_CORE_RX: trig = host_rd;
      XM_CORE_TX: trig = host_wr;
      XM_DMA:     trig = dma_kick;
      default:    trig = 1'b0;
    endcase
  end

  assign start_req = port_en && (trig || pend_q);
  assign eng_start = start_req && !eng_busy;
  assign eng_tx    = host_wr ? tx_wdata : (dma_wr ? dma_wdata : tx_buf_q);

  spi_shift_engine #(.WIDTH(WIDTH), .CLK_DIV(CLK_DIV)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (!port_en),
    .start   (eng_start),
    .tx_word (eng_tx),
    .miso    (miso),
    .busy    (eng_busy),
    .sclk    (sclk),
    .mosi    (mosi),
    .done    (eng_done),
    .rx_word (eng_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
      tx_buf_q  <= '0;
      rx_buf_q  <= '0;
    end else begin
      pend_q <= start_req && eng_busy;
      if (host_wr || dma_wr) tx_buf_q <= eng_tx;
      if (!port_en)                 tx_full_q <= 1'b0;
      else if (eng_start)           tx_full_q <= 1'b0;
      else if (host_wr || dma_wr)   tx_full_q <= 1'b1;
      if (eng_done) rx_buf_q <= eng_rx;
      if (!port_en)                 rx_full_q <= 1'b0;
      else if (eng_done)            rx_full_q <= 1'b1;
      else if (host_rd || dma_rd)   rx_full_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (mode_e)
      XM_CORE_RX: irq = port_en && rx_full_q && !rx_rd;
      XM_CORE_TX: irq = port_en && !tx_full_q && !tx_wr;
      XM_DMA:     irq = port_en && dma_last;
      default:    irq = 1'b0;
    endcase
  end

  assign rx_data = rx_buf_q;

  // R11: reserved mode never starts a word nor raises the interrupt
  assert_reserved_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> (!eng_start && !irq));
  // R12: a disabled port has empty buffers on the next cycle
  assert_disable_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!rx_full_q && !tx_full_q));
  // R4: a finished word always lands in the receive buffer
  assert_done_fills_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && port_en) |=> rx_full_q);
endmodule

// File: tb/spi_xfer_ctrl_tb.sv
module spi_xfer_ctrl_tb;
  localparam int CLK_DIV = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       port_en = 1'b0, rcv_dir = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] tx_wdata = '0, rx_data, dma_len = '0, dma_wdata = '0;
  logic       irq, dma_en = 1'b0, dma_req, dma_ack = 1'b0;
  logic       sclk, mosi, miso;

  always #10 clk = ~clk;

  spi_xfer_ctrl #(.WIDTH(8), .CLK_DIV(CLK_DIV), .CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .mode(mode), .rcv_dir(rcv_dir),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_data(rx_data), .irq(irq),
    .dma_en(dma_en), .dma_len(dma_len), .dma_req(dma_req), .dma_ack(dma_ack),
    .dma_wdata(dma_wdata), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rise_cnt = 0, fcnt = 0, irq_cnt = 0, irq_last = -1;
  int rise_t [0:255];
  logic [31:0] mcap = '0;
  logic        sclk_p = 1'b0;
  logic [15:0] slave_word = '0;
  int          fbase = 0;
  bit          dma_on = 1'b0, fin = 1'b0;
  logic [7:0]  dsrc [0:3];
  logic [7:0]  dcap [0:3];
  int          ack_n = 0, abase = 0, last_ack = -1;

  // Slave model: MSB of the loaded word first, advancing on each falling sclk.
  always_comb begin
    int k;
    k = fcnt - fbase;
    miso = (k >= 0 && k < 16) ? slave_word[15 - k] : 1'b0;
  end

  // Monitor and DMA responder, all sampled at the falling clk edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sclk && !sclk_p) begin
      rise_t[rise_cnt % 256] = cyc;
      mcap = {mcap[30:0], mosi};
      rise_cnt = rise_cnt + 1;
    end
    if (!sclk && sclk_p) fcnt = fcnt + 1;
    sclk_p = sclk;
    if (irq) begin irq_cnt = irq_cnt + 1; irq_last = cyc; end
    if (dma_on && dma_req && !dma_ack) begin
      dma_ack   = 1'b1;
      dma_wdata = dsrc[(ack_n - abase) % 4];
      dcap[(ack_n - abase) % 4] = rx_data;
      ack_n    = ack_n + 1;
      last_ack = cyc;
    end else begin
      dma_ack = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_slave(input logic [15:0] w);
    slave_word = w;
    fbase = fcnt;
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic t_reset();
    #2;
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(mosi == 1'b0, "R1 mosi", mosi, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(dma_req == 1'b0, "R1 dma_req", dma_req, 0);
  endtask

  task automatic t_core_rx();
    int r0;
    r0 = rise_cnt;
    @(negedge clk); mode = 2'b00; port_en = 1'b1;
    wait_n(40);
    chk(rise_cnt == r0, "R2 no clock before dummy read", rise_cnt - r0, 0);
    chk(irq == 1'b0, "R3 irq low with empty rx", irq, 0);
    pulse_wr(8'hA5);
    wait_n(10);
    chk(rise_cnt == r0, "R2 write does not start", rise_cnt - r0, 0);
    load_slave({8'h3C, 8'h00});
    pulse_rd();
    wait_n(45);
    chk(rise_cnt - r0 == 8, "R2 one word after read", rise_cnt - r0, 8);
    chk(mcap[7:0] == 8'hA5, "R6 mosi msb first", mcap[7:0], 8'hA5);
    chk(rx_data == 8'h3C, "R6 miso sampled", rx_data, 8'h3C);
    chk(rise_t[(r0 + 1) % 256] - rise_t[r0 % 256] == CLK_DIV, "R6 sclk period",
        rise_t[(r0 + 1) % 256] - rise_t[r0 % 256], CLK_DIV);
    chk(irq == 1'b1, "R3 irq while rx full", irq, 1);
    load_slave({8'h96, 8'h00});
    @(negedge clk); rx_rd = 1'b1; #2;
    chk(irq == 1'b0, "R3 irq drops in read cycle", irq, 0);
    @(negedge clk); rx_rd = 1'b0;
    wait_n(45);
    chk(rx_data == 8'h96, "R2 read starts next word", rx_data, 8'h96);
    chk(mcap[7:0] == 8'hA5, "R2 tx buffer reused", mcap[7:0], 8'hA5);
    @(negedge clk); port_en = 1'b0; #2;
    chk(irq == 1'b0, "R3 irq drops with enable", irq, 0);
  endtask

  task automatic t_core_tx();
    int r0;
    r0 = rise_cnt;
    @(negedge clk); mode = 2'b01; port_en = 1'b1; #2;
    chk(irq == 1'b1, "R5 irq while tx empty", irq, 1);
    load_slave({8'h11, 8'h22});
    @(negedge clk); tx_wr = 1'b1; tx_wdata = 8'hC3; #2;
    chk(irq == 1'b0, "R5 irq low in write cycle", irq, 0);
    @(negedge clk); tx_wr = 1'b0; #2;
    chk(irq == 1'b1, "R5 irq back once word shifts", irq, 1);
    wait_n(5);
    pulse_wr(8'h5A);
    #2;
    chk(irq == 1'b0, "R5 irq low while word waits", irq, 0);
    wait_n(80);
    chk(rise_cnt - r0 == 16, "R7 pending word sent", rise_cnt - r0, 16);
    chk(mcap[15:0] == 16'hC35A, "R4 words shifted out", mcap[15:0], 16'hC35A);
    chk(rx_data == 8'h22, "R4 received byte", rx_data, 8'h22);
    chk(rise_t[(r0 + 8) % 256] - rise_t[(r0 + 7) % 256] == CLK_DIV + 1, "R7 one-cycle gap",
        rise_t[(r0 + 8) % 256] - rise_t[(r0 + 7) % 256], CLK_DIV + 1);
    chk(irq == 1'b1, "R5 irq after both words", irq, 1);
    @(negedge clk); port_en = 1'b0;
  endtask

  task automatic t_dma_tx();
    int r0, i0;
    r0 = rise_cnt; i0 = irq_cnt;
    dsrc[0] = 8'hE1; dsrc[1] = 8'h7E; dsrc[2] = 8'h0F;
    @(negedge clk); mode = 2'b10; rcv_dir = 1'b0; dma_len = 8'd3; port_en = 1'b1;
    abase = ack_n; dma_on = 1'b1;
    @(negedge clk); dma_en = 1'b1;
    wait_n(130);
    chk(ack_n - abase == 3, "R8 acknowledged words", ack_n - abase, 3);
    chk(rise_cnt - r0 == 24, "R8 words sent", rise_cnt - r0, 24);
    chk(mcap[23:0] == 24'hE17E0F, "R8 dma data order", mcap[23:0], 24'hE17E0F);
    chk(irq_cnt - i0 == 1, "R10 single irq pulse", irq_cnt - i0, 1);
    chk(irq_last == last_ack + 1, "R10 pulse after last ack", irq_last, last_ack + 1);
    chk(dma_req == 1'b0, "R8 no request after count", dma_req, 0);
    @(negedge clk); dma_on = 1'b0; dma_en = 1'b0; port_en = 1'b0;
  endtask

  task automatic t_dma_rx();
    int r0, i0;
    r0 = rise_cnt; i0 = irq_cnt;
    load_slave({8'hB4, 8'h4B});
    @(negedge clk); mode = 2'b10; rcv_dir = 1'b1; dma_len = 8'd2; port_en = 1'b1;
    abase = ack_n; dma_on = 1'b1;
    @(negedge clk); dma_en = 1'b1;
    wait_n(110);
    chk(rise_cnt - r0 == 16, "R9 two words received", rise_cnt - r0, 16);
    chk(ack_n - abase == 2, "R9 two reads", ack_n - abase, 2);
    chk(dcap[0] == 8'hB4, "R9 first word", dcap[0], 8'hB4);
    chk(dcap[1] == 8'h4B, "R9 second word", dcap[1], 8'h4B);
    chk(irq_cnt - i0 == 1, "R10 rx single pulse", irq_cnt - i0, 1);
    @(negedge clk); dma_on = 1'b0; dma_en = 1'b0; port_en = 1'b0; rcv_dir = 1'b0;
  endtask

  task automatic t_reserved();
    int r0, i0;
    r0 = rise_cnt; i0 = irq_cnt;
    @(negedge clk); mode = 2'b11; port_en = 1'b1;
    pulse_wr(8'h33);
    pulse_rd();
    wait_n(50);
    chk(rise_cnt == r0, "R11 no word in reserved", rise_cnt - r0, 0);
    chk(irq_cnt == i0, "R11 irq stays low", irq_cnt - i0, 0);
    @(negedge clk); port_en = 1'b0;
  endtask

  task automatic t_abort();
    int rc;
    load_slave({8'hFF, 8'h00});
    @(negedge clk); mode = 2'b01; port_en = 1'b1;
    pulse_wr(8'hFF);
    wait_n(12);
    @(negedge clk); port_en = 1'b0;
    @(negedge clk); #2;
    chk(sclk == 1'b0, "R12 sclk low after abort", sclk, 0);
    rc = rise_cnt;
    pulse_wr(8'h44);
    wait_n(50);
    chk(rise_cnt == rc, "R12 strobes ignored when off", rise_cnt - rc, 0);
    chk(irq == 1'b0, "R12 irq low when off", irq, 0);
    @(negedge clk); mode = 2'b00; port_en = 1'b1;
    pulse_rd();
    wait_n(45);
    chk(irq == 1'b1, "R12 rx filled before disable", irq, 1);
    @(negedge clk); port_en = 1'b0;
    @(negedge clk); port_en = 1'b1; #2;
    chk(irq == 1'b0, "R12 rx emptied by disable", irq, 0);
    @(negedge clk); port_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_core_rx();
    t_core_tx();
    t_dma_tx();
    t_dma_rx();
    t_reserved();
    t_abort();
    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule